// File: doc/BRIEF.md
# Mode Command Subsystem Signaling Unit

This unit sits between the command checker of a serial-bus remote terminal and the attached subsystem. It receives each command word once the word is fully validated. It then picks out the mode commands, which carry subaddress 0 or 31. A mode command uses no block-data handshake. It is turned into one of four active-low subsystem lines: a synchronize line, a vector-word enable, a reset pulse, or a request to take over bus control.

Two of the mode commands move one 16-bit word over the byte-wide subsystem highway. The high byte goes first, marked by a high/low indicator, and each byte has a single-cycle byte strobe. For synchronize-with-data, the received word goes out to the subsystem. For transmit-vector, the word comes in from the subsystem and is handed back to the transmitter. Neither transfer waits for the subsystem to acknowledge, and neither is held back by a busy condition. The sequence runs for a fixed number of cycles.

Mode codes that the terminal services by itself cause no activity on the subsystem lines. This includes codes whose transmit/receive bit does not match the code.

Top module: `mode_sig_unit`

## Requirements
- R1: After reset, all four active-low lines (`sync_n`, `vectorEn_n`, `resetPulse_n`, `busCtrlReq_n`) are high, and `byteStrobe`, `hiLo` and `vectorValid` are low.
- R2: A command whose subaddress is neither 0 nor 31 produces no activity on any output, whatever its code.
- R3: Code 00001 with transmit bit 1 drives `sync_n` low for exactly `PULSE_W` cycles. The pulse starts in the cycle after `cmdValid`, and `syncVariant` reads 0 during it.
- R4: Code 10001 with transmit bit 0 drives `sync_n` low from the cycle after `cmdValid`, and `syncVariant` reads 1. After `dataValid`, four transfer cycles follow:
  - the first two have `hiLo`=1 and put the high byte on `highwayOut`;
  - the last two have `hiLo`=0 and put the low byte on `highwayOut`;
  - `byteStrobe` is 1 in the first cycle of each pair.
  - `sync_n` returns high after the fourth cycle.
- R5: Code 10000 with transmit bit 1 drives `vectorEn_n` low for four cycles, starting the cycle after `cmdValid`. These cycles follow the same `hiLo` and `byteStrobe` pattern as in R4. `highwayIn` is read in each strobe cycle. In the fourth cycle `vectorValid` is 1 and `vectorWord` holds {high byte, low byte}.
- R6: Code 01000 with transmit bit 1 drives `resetPulse_n` low for exactly `PULSE_W` cycles, starting the cycle after `cmdValid`.
- R7: Code 00000 with transmit bit 1 drives `busCtrlReq_n` low for `PULSE_W` cycles only if `busAccept_n` is 0 in the `cmdValid` cycle. Otherwise it produces nothing.
- R8: Any other code, or one of the codes above with the opposite transmit bit, produces no activity on any output.
- R9: A new `cmdValid` cancels any activity in progress, and the new command is decoded as if the unit were idle.
- R10: `dataValid` has no effect unless a synchronize-with-data command is waiting for its word.
- R11: At most one of the four active-low lines is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | One-cycle pulse: a validated command word for this terminal |
| cmdSubAddr | input | 5 | Subaddress field of the command |
| cmdTx | input | 1 | Transmit/receive bit of the command (1 = transmit) |
| cmdCode | input | 5 | Word count / mode code field of the command |
| busAccept_n | input | 1 | Tied accept for bus-control takeover, active low |
| dataValid | input | 1 | One-cycle pulse: a validated data word is on `dataWord` |
| dataWord | input | WORD_W | Received data word |
| highwayIn | input | WORD_W/2 | Byte driven by the subsystem during vector reads |
| highwayOut | output | WORD_W/2 | Byte sent to the subsystem during synchronize-data transfers |
| byteStrobe | output | 1 | Byte strobe, one cycle per byte |
| hiLo | output | 1 | 1 while the high byte is being transferred |
| sync_n | output | 1 | Synchronize line, active low |
| syncVariant | output | 1 | Bit 4 of the last synchronize code (1 = with data) |
| vectorEn_n | output | 1 | Vector word enable, active low |
| vectorValid | output | 1 | Vector word assembled on `vectorWord` |
| vectorWord | output | WORD_W | Vector word read from the subsystem |
| resetPulse_n | output | 1 | Subsystem reset pulse, active low |
| busCtrlReq_n | output | 1 | Bus control takeover request, active low |

## Verification
The hardest case to reach is a command that arrives while a synchronize-with-data command is still waiting for its word. From the ports this needs a precise order: the sync command, an open-ended gap with no data, and then a second mode command before `dataValid` appears. The bench drives this as a directed sequence and checks that the sync line is released and the reset pulse starts in the very next cycle.

Random commands drawn from a seeded generator also vary the wait before `dataValid`. Each run of random commands follows a data word sent into idle, which confirms that a stray word is dropped.

// File: rtl/mode_sig_pkg.sv
package mode_sig_pkg;

  typedef enum logic [2:0] {
    K_NONE, K_SYNC, K_SYNCD, K_VEC, K_RST, K_DBC
  } kind_t;

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_WAITD, S_XFER} state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic capHigh;
    logic capLow;
    logic selHigh;
  } dp_ctrl_t;

  localparam logic [5:0] TC_SYNC  = 6'b1_00001;
  localparam logic [5:0] TC_SYNCD = 6'b0_10001;
  localparam logic [5:0] TC_VEC   = 6'b1_10000;
  localparam logic [5:0] TC_RST   = 6'b1_01000;
  localparam logic [5:0] TC_DBC   = 6'b1_00000;

endpackage

// File: rtl/mode_sig_ctrl.sv
module mode_sig_ctrl
  import mode_sig_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic [4:0] cmdSubAddr,
  input  logic       cmdTx,
  input  logic [4:0] cmdCode,
  input  logic       busAccept_n,
  input  logic       dataValid,
  output dp_ctrl_t   dpCtrl,
  output logic       byteStrobe,
  output logic       hiLo,
  output logic       sync_n,
  output logic       syncVariant,
  output logic       vectorEn_n,
  output logic       vectorValid,
  output logic       resetPulse_n,
  output logic       busCtrlReq_n
);

  localparam int CNT_W = $clog2(PULSE_W + 1);

  state_t           state;
  kind_t            kind;
  kind_t            cmdKind;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       phase;
  logic             isMode;
  logic             active;

  assign isMode = (cmdSubAddr == 5'd0) || (cmdSubAddr == 5'd31);

  always_comb begin
    cmdKind = K_NONE;
    if (isMode) begin
      case ({cmdTx, cmdCode})
        TC_SYNC:  cmdKind = K_SYNC;
        TC_SYNCD: cmdKind = K_SYNCD;
        TC_VEC:   cmdKind = K_VEC;
        TC_RST:   cmdKind = K_RST;
        TC_DBC:   cmdKind = busAccept_n ? K_NONE : K_DBC;
        default:  cmdKind = K_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      kind        <= K_NONE;
      cnt         <= '0;
      phase       <= '0;
      syncVariant <= 1'b0;
    end else if (cmdValid) begin
      kind  <= cmdKind;
      phase <= '0;
      cnt   <= CNT_W'(PULSE_W - 1);
      if (cmdKind == K_SYNC || cmdKind == K_SYNCD) syncVariant <= cmdCode[4];
      case (cmdKind)
        K_NONE:  state <= S_IDLE;
        K_SYNCD: state <= S_WAITD;
        K_VEC:   state <= S_XFER;
        default: state <= S_PULSE;
      endcase
    end else begin
      case (state)
        S_PULSE: begin
          if (cnt == '0) begin
            state <= S_IDLE;
            kind  <= K_NONE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WAITD: if (dataValid) state <= S_XFER;
        S_XFER: begin
          phase <= phase + 1'b1;
          if (phase == 2'd3) begin
            state <= S_IDLE;
            kind  <= K_NONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign active       = (state != S_IDLE);
  assign sync_n       = !(active && (kind == K_SYNC || kind == K_SYNCD));
  assign vectorEn_n   = !(active && kind == K_VEC);
  assign resetPulse_n = !(active && kind == K_RST);
  assign busCtrlReq_n = !(active && kind == K_DBC);
  assign byteStrobe   = (state == S_XFER) && !phase[0];
  assign hiLo         = (state == S_XFER) && !phase[1];
  assign vectorValid  = (state == S_XFER) && (kind == K_VEC) && (phase == 2'd3);

  assign dpCtrl.loadData = (state == S_WAITD) && dataValid && !cmdValid;
  assign dpCtrl.capHigh  = (state == S_XFER) && (kind == K_VEC) && (phase == 2'd0);
  assign dpCtrl.capLow   = (state == S_XFER) && (kind == K_VEC) && (phase == 2'd2);
  assign dpCtrl.selHigh  = hiLo;

  // R11
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!sync_n, !vectorEn_n, !resetPulse_n, !busCtrlReq_n}) <= 1);

  // R6
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resetPulse_n) |-> $past(cmdValid));

  // R4
  strobe_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byteStrobe |-> (!sync_n || !vectorEn_n));

  // R4
  high_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byteStrobe && hiLo && !cmdValid) |=> (hiLo && !byteStrobe));

  // R10
  stray_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && dataValid && !cmdValid) |=> !byteStrobe);

endmodule

// File: rtl/mode_sig_dp.sv
module mode_sig_dp
  import mode_sig_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dp_ctrl_t            dpCtrl,
  input  logic [WORD_W-1:0]   dataWord,
  input  logic [WORD_W/2-1:0] highwayIn,
  output logic [WORD_W/2-1:0] highwayOut,
  output logic [WORD_W-1:0]   vectorWord
);

  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] xferWord;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xferWord   <= '0;
      vectorWord <= '0;
    end else begin
      if (dpCtrl.loadData) xferWord <= dataWord;
      if (dpCtrl.capHigh)  vectorWord[WORD_W-1:HALF] <= highwayIn;
      if (dpCtrl.capLow)   vectorWord[HALF-1:0]      <= highwayIn;
    end
  end

  assign highwayOut = dpCtrl.selHigh ? xferWord[WORD_W-1:HALF] : xferWord[HALF-1:0];

  // R4
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dpCtrl.loadData |=> (!dpCtrl.selHigh || highwayOut == $past(dataWord[WORD_W-1:HALF])));

endmodule

// File: rtl/mode_sig_unit.sv
module mode_sig_unit
  import mode_sig_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int PULSE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmdValid,
  input  logic [4:0]          cmdSubAddr,
  input  logic                cmdTx,
  input  logic [4:0]          cmdCode,
  input  logic                busAccept_n,
  input  logic                dataValid,
  input  logic [WORD_W-1:0]   dataWord,
  input  logic [WORD_W/2-1:0] highwayIn,
  output logic [WORD_W/2-1:0] highwayOut,
  output logic                byteStrobe,
  output logic                hiLo,
  output logic                sync_n,
  output logic                syncVariant,
  output logic                vectorEn_n,
  output logic                vectorValid,
  output logic [WORD_W-1:0]   vectorWord,
  output logic                resetPulse_n,
  output logic                busCtrlReq_n
);

  dp_ctrl_t dpCtrl;

  mode_sig_ctrl #(.PULSE_W(PULSE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdSubAddr(cmdSubAddr),
    .cmdTx(cmdTx), .cmdCode(cmdCode), .busAccept_n(busAccept_n),
    .dataValid(dataValid), .dpCtrl(dpCtrl), .byteStrobe(byteStrobe),
    .hiLo(hiLo), .sync_n(sync_n), .syncVariant(syncVariant),
    .vectorEn_n(vectorEn_n), .vectorValid(vectorValid),
    .resetPulse_n(resetPulse_n), .busCtrlReq_n(busCtrlReq_n)
  );

  mode_sig_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .dpCtrl(dpCtrl), .dataWord(dataWord),
    .highwayIn(highwayIn), .highwayOut(highwayOut), .vectorWord(vectorWord)
  );

endmodule

// File: tb/tb_mode_sig_unit.sv
module tb_mode_sig_unit;

  localparam int WORD_W  = 16;
  localparam int HALF    = WORD_W / 2;
  localparam int PULSE_W = 4;
  localparam int KN = 0, KS = 1, KSD = 2, KV = 3, KR = 4, KD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [4:0] cmdSubAddr = '0;
  logic cmdTx = 1'b0;
  logic [4:0] cmdCode = '0;
  logic busAccept_n = 1'b1;
  logic dataValid = 1'b0;
  logic [WORD_W-1:0] dataWord = '0;
  logic [WORD_W-1:0] vecWord = 16'hA55A;
  logic [HALF-1:0] highwayIn;
  logic [HALF-1:0] highwayOut;
  logic byteStrobe, hiLo, sync_n, syncVariant, vectorEn_n, vectorValid;
  logic [WORD_W-1:0] vectorWord;
  logic resetPulse_n, busCtrlReq_n;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // subsystem model: presents the vector byte selected by hiLo
  assign highwayIn = hiLo ? vecWord[WORD_W-1:HALF] : vecWord[HALF-1:0];

  mode_sig_unit #(.WORD_W(WORD_W), .PULSE_W(PULSE_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdSubAddr(cmdSubAddr),
    .cmdTx(cmdTx), .cmdCode(cmdCode), .busAccept_n(busAccept_n),
    .dataValid(dataValid), .dataWord(dataWord), .highwayIn(highwayIn),
    .highwayOut(highwayOut), .byteStrobe(byteStrobe), .hiLo(hiLo),
    .sync_n(sync_n), .syncVariant(syncVariant), .vectorEn_n(vectorEn_n),
    .vectorValid(vectorValid), .vectorWord(vectorWord),
    .resetPulse_n(resetPulse_n), .busCtrlReq_n(busCtrlReq_n)
  );

  function automatic int classify(logic [4:0] sa, logic tx, logic [4:0] code, logic acc);
    if (sa != 5'd0 && sa != 5'd31) return KN;
    case ({tx, code})
      6'b1_00001: return KS;
      6'b0_10001: return KSD;
      6'b1_10000: return KV;
      6'b1_01000: return KR;
      6'b1_00000: return acc ? KN : KD;
      default:    return KN;
    endcase
  endfunction

  function automatic string tagOf(int k);
    case (k)
      KS: return "R3"; KSD: return "R4"; KV: return "R5";
      KR: return "R6"; KD: return "R7"; default: return "R8";
    endcase
  endfunction

  function automatic logic [5:0] pulseExp(int k, int i);
    return {!(k == KS && i < PULSE_W), 1'b1, !(k == KR && i < PULSE_W),
            !(k == KD && i < PULSE_W), 1'b0, 1'b0};
  endfunction

  function automatic logic [5:0] xferExp(int k, int j);
    logic on = (j < 4);
    return {!(k == KSD && on), !(k == KV && on), 1'b1, 1'b1,
            on && (j % 2 == 0), j < 2};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {sync_n, vectorEn_n, resetPulse_n, busCtrlReq_n, byteStrobe, hiLo};
  endfunction

  task automatic oneCheck(string tag, logic [5:0] exp);
    chk(tag, {26'd0, outs()}, {26'd0, exp});
    // R11
    chk("R11", 32'($countones({!sync_n, !vectorEn_n, !resetPulse_n, !busCtrlReq_n}) <= 1), 32'd1);
  endtask

  task automatic driveCmd(logic [4:0] sa, logic tx, logic [4:0] code, logic acc);
    cmdSubAddr = sa; cmdTx = tx; cmdCode = code; busAccept_n = acc; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic runCmd(logic [4:0] sa, logic tx, logic [4:0] code, logic acc,
                        int gap, logic [WORD_W-1:0] word);
    int k = classify(sa, tx, code, acc);
    string t = tagOf(k);
    if (sa != 5'd0 && sa != 5'd31) t = "R2";
    driveCmd(sa, tx, code, acc);
    if (k == KV) begin
      for (int j = 0; j <= 4; j++) begin
        oneCheck(t, xferExp(k, j));
        chk("R5 valid", 32'(vectorValid), 32'(j == 3));
        if (j == 3) chk("R5 word", 32'(vectorWord), 32'(vecWord));
        @(negedge clk);
      end
    end else if (k == KSD) begin
      chk("R4 variant", 32'(syncVariant), 32'd1);
      for (int i = 0; i < gap; i++) begin
        oneCheck(t, 6'b011100);
        @(negedge clk);
      end
      dataValid = 1'b1; dataWord = word;
      @(negedge clk);
      dataValid = 1'b0;
      for (int j = 0; j <= 4; j++) begin
        oneCheck(t, xferExp(k, j));
        if (j < 4) chk("R4 byte", 32'(highwayOut),
                       32'(j < 2 ? word[WORD_W-1:HALF] : word[HALF-1:0]));
        @(negedge clk);
      end
    end else begin
      if (k == KS) chk("R3 variant", 32'(syncVariant), 32'd0);
      for (int i = 0; i <= PULSE_W + 1; i++) begin
        oneCheck(t, pulseExp(k, i));
        @(negedge clk);
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1553));
    repeat (3) @(negedge clk);
    // R1
    oneCheck("R1", 6'b111100);
    chk("R1 valid", 32'(vectorValid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    oneCheck("R1", 6'b111100);

    // directed corners
    runCmd(5'd0,  1'b1, 5'b00001, 1'b1, 0, '0);        // R3
    runCmd(5'd31, 1'b0, 5'b10001, 1'b1, 3, 16'h12EF);  // R4
    runCmd(5'd0,  1'b1, 5'b10000, 1'b1, 0, '0);        // R5
    runCmd(5'd31, 1'b1, 5'b01000, 1'b1, 0, '0);        // R6
    runCmd(5'd0,  1'b1, 5'b00000, 1'b0, 0, '0);        // R7 accepted
    runCmd(5'd0,  1'b1, 5'b00000, 1'b1, 0, '0);        // R7 refused
    runCmd(5'd5,  1'b1, 5'b00001, 1'b1, 0, '0);        // R2
    runCmd(5'd0,  1'b0, 5'b01000, 1'b1, 0, '0);        // R8 wrong T/R
    runCmd(5'd31, 1'b1, 5'b00010, 1'b0, 0, '0);        // R8 internal code

    // R10: stray data word while idle
    dataValid = 1'b1; dataWord = 16'hBEEF;
    @(negedge clk);
    dataValid = 1'b0;
    oneCheck("R10", 6'b111100);
    @(negedge clk);
    oneCheck("R10", 6'b111100);

    // R9: sync-with-data pending, reset command arrives first
    driveCmd(5'd0, 1'b0, 5'b10001, 1'b1);
    @(negedge clk);
    oneCheck("R9", 6'b011100);
    driveCmd(5'd0, 1'b1, 5'b01000, 1'b1);
    oneCheck("R9", 6'b110100);
    repeat (PULSE_W) @(negedge clk);
    oneCheck("R9", 6'b111100);
    dataValid = 1'b1;
    @(negedge clk);
    dataValid = 1'b0;
    oneCheck("R10", 6'b111100);

    // constrained random commands
    for (int n = 0; n < 80; n++) begin
      logic [4:0] sa;
      logic [4:0] code;
      logic [5:0] picks [6] = '{6'b1_00001, 6'b0_10001, 6'b1_10000,
                                6'b1_01000, 6'b1_00000, 6'b1_00010};
      logic [5:0] tc;
      int r = $urandom % 4;
      sa = (r == 0) ? 5'($urandom) : ((r == 1) ? 5'd0 : 5'd31);
      tc = picks[$urandom % 6];
      if ($urandom % 5 == 0) tc[5] = ~tc[5];
      code = tc[4:0];
      vecWord = 16'($urandom);
      runCmd(sa, tc[5], code, 1'($urandom), int'($urandom % 5), 16'($urandom));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule